// File: doc/BRIEF.md
# Transmit Flow-Control Credit Monitor

The block keeps a running count of the transmit credits that the link partner has granted, split into six pools: a header pool and a data pool for each of the posted, non-posted and completion transaction classes. A data credit covers 16 bytes (4 dwords) of payload. The user-side transmit logic reads a packed 36-bit status vector in which every pool has a small saturating field. A field shows its ceiling value while the true count is above that ceiling. It follows the true count only once enough credits have been spent to bring it into range.

A flow-control initialization event loads all six limits at once. A limit of zero marks a pool as unlimited. Consumption pulses and credit-return updates each name a class and carry a header amount and a data amount. For the non-posted pools the block raises a flag when the pool was granted exactly one credit. In that case the field cannot be trusted, and the user logic infers credit release from arriving completions. The block also raises a sticky flag when more non-posted credits are spent than were available. The block only reports. It never holds back transmission.

Top module: `tx_credit_monitor`

## Requirements
- R1: After reset every status field, both single-credit flags and both violation flags read 0. Every pool is finite with a count of 0.
- R2: Status vector layout, from bit 0: posted header [2:0], posted data [14:3], non-posted header [17:15], non-posted data [20:18], completion header [23:21], completion data [35:24].
- R3: A cycle with `fc_init_i` high loads each pool count from its 16-bit slice of `init_limit_i`, in slice order posted header, posted data, non-posted header, non-posted data, completion header, completion data. Slice 0 is the least significant. Consumption and return in the same cycle are ignored. Every status and flag output changes on the clock edge that takes the event, one cycle later.
- R4: Each status field shows min(count, max), where max is 7 for the 3-bit fields and 4095 for the 12-bit fields.
- R5: A cycle with `consume_i` high subtracts `consume_hdr_i` from the header pool and `consume_data_i` from the data pool of class `consume_class_i`. Class codes are 0 posted, 1 non-posted, 2 completion. Code 3 touches no pool.
- R6: A cycle with `return_i` high adds `return_hdr_i` and `return_data_i` to the pools of class `return_class_i`, using the same class codes. The count saturates at 65535.
- R7: When consumption and return hit the same pool in one cycle, the return is applied first. The result is floored at 0.
- R8: A pool initialized with limit 0 is unlimited. Its field shows its max, consumption and return leave it unchanged, and it never flags a violation.
- R9: Each non-posted single-credit flag is set by an initialization whose limit for that pool is exactly 1. Any initialization with another limit clears it.
- R10: A non-posted violation flag is set when a consumption on that finite pool exceeds the count available after any same-cycle return. It stays set through later initializations and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fc_init_i | input | 1 | Flow-control (re)initialization strobe |
| init_limit_i | input | 96 | Six 16-bit initial limits, pool order as in R3 |
| consume_i | input | 1 | Consumption strobe |
| consume_class_i | input | 2 | Consumption class code |
| consume_hdr_i | input | 8 | Header credits consumed |
| consume_data_i | input | 16 | Data credits consumed |
| return_i | input | 1 | Credit-return strobe |
| return_class_i | input | 2 | Return class code |
| return_hdr_i | input | 8 | Header credits returned |
| return_data_i | input | 16 | Data credits returned |
| cred_status_o | output | 36 | Packed saturating credit fields |
| np_hdr_one_o | output | 1 | Non-posted header pool granted a single credit |
| np_data_one_o | output | 1 | Non-posted data pool granted a single credit |
| np_hdr_viol_o | output | 1 | Sticky non-posted header over-consumption |
| np_data_viol_o | output | 1 | Sticky non-posted data over-consumption |

## Verification
A long pseudo-random stream mixes consumption, return and combined cycles on every class code, including the unused code. Periodic reinitializations draw small limits that put the counts near the 3-bit and 12-bit ceilings, and that sometimes choose 0 or 1. These patterns separate a saturating display from a wrapped one, return-first ordering from consume-first ordering, and unlimited pools from finite ones. Directed sequences pin down the field positions with distinct limits per pool, the 65535 ceiling of the counts, violation persistence across reinitialization, and the clearing of the flags by reset.

// File: rtl/tx_credit_pkg.sv
package tx_credit_pkg;
  localparam int NPOOL   = 6;
  localparam int NCLASS  = 3;
  localparam int CNT_W   = 16;
  localparam int AMT_H_W = 8;
  localparam int HDR_FW  = 3;
  localparam int DAT_FW  = 12;

  typedef enum logic [1:0] {
    CLS_POSTED = 2'd0,
    CLS_NONPOSTED = 2'd1,
    CLS_COMPL = 2'd2,
    CLS_NONE = 2'd3
  } cls_e;

  // pool p: class p/2, data pool when p is odd
  function automatic int pool_fw(int p);
    return ((p % 2) == 1 && p != 3) ? DAT_FW : HDR_FW;
  endfunction

  function automatic int pool_lsb(int p);
    int acc = 0;
    for (int i = 0; i < p; i++) acc += pool_fw(i);
    return acc;
  endfunction

  localparam int STATUS_W = pool_lsb(NPOOL);
  localparam int NPH_IDX = 2;
  localparam int NPD_IDX = 3;
endpackage

// File: rtl/tx_credit_decode.sv
module tx_credit_decode
  import tx_credit_pkg::*;
(
  input  logic                   consume_i,
  input  logic [1:0]             consume_class_i,
  input  logic [AMT_H_W-1:0]     consume_hdr_i,
  input  logic [CNT_W-1:0]       consume_data_i,
  input  logic                   return_i,
  input  logic [1:0]             return_class_i,
  input  logic [AMT_H_W-1:0]     return_hdr_i,
  input  logic [CNT_W-1:0]       return_data_i,
  output logic [NPOOL*CNT_W-1:0] cons_amt_o,
  output logic [NPOOL*CNT_W-1:0] ret_amt_o
);
  localparam logic [CNT_W-AMT_H_W-1:0] PAD = '0;

  for (genvar p = 0; p < NPOOL; p++) begin : g_pool
    localparam logic [1:0] CLS = 2'(p / 2);
    localparam bit IS_DATA = (p % 2) == 1;
    logic [CNT_W-1:0] c_amt, r_amt;

    if (IS_DATA) begin : g_dat
      assign c_amt = consume_data_i;
      assign r_amt = return_data_i;
    end else begin : g_hdr
      assign c_amt = {PAD, consume_hdr_i};
      assign r_amt = {PAD, return_hdr_i};
    end

    assign cons_amt_o[p*CNT_W +: CNT_W] =
      (consume_i && consume_class_i == CLS) ? c_amt : '0;
    assign ret_amt_o[p*CNT_W +: CNT_W] =
      (return_i && return_class_i == CLS) ? r_amt : '0;
  end
endmodule

// File: rtl/tx_credit_pool.sv
module tx_credit_pool #(
  parameter int CW        = 16,
  parameter int FW        = 3,
  parameter bit HAS_FLAGS = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [CW-1:0] limit_i,
  input  logic [CW-1:0] cons_i,
  input  logic [CW-1:0] ret_i,
  output logic [FW-1:0] field_o,
  output logic          one_o,
  output logic          viol_o
);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [FW-1:0] F_MAX   = '1;
  localparam logic [CW-1:0] F_MAX_W = {{(CW-FW){1'b0}}, F_MAX};
  localparam logic [CW-1:0] ONE_W   = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, after_ret;
  logic [CW:0]   sum;
  logic          inf_q, inf_d, over, viol_set;
  logic [FW-1:0] field_d;

  always_comb begin
    sum       = {1'b0, cnt_q} + {1'b0, ret_i};
    after_ret = sum[CW] ? CNT_MAX : sum[CW-1:0];
    over      = cons_i > after_ret;
    cnt_d     = cnt_q;
    inf_d     = inf_q;
    if (init_i) begin
      cnt_d = limit_i;
      inf_d = (limit_i == '0);
    end else if (!inf_q) begin
      cnt_d = over ? '0 : after_ret - cons_i;
    end
    if (inf_d)                field_d = F_MAX;
    else if (cnt_d > F_MAX_W) field_d = F_MAX;
    else                      field_d = cnt_d[FW-1:0];
    viol_set = !init_i && !inf_q && over;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      inf_q   <= 1'b0;
      field_o <= '0;
    end else begin
      cnt_q   <= cnt_d;
      inf_q   <= inf_d;
      field_o <= field_d;
    end
  end

  // R3
  init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (cnt_q == $past(limit_i)));

  // R8
  inf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inf_q && !init_i) |=> (field_o == F_MAX && $stable(cnt_q)));

  // R5
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && cons_i == '0 && ret_i == '0) |=> $stable(cnt_q));

  if (HAS_FLAGS) begin : g_flags
    logic one_q, viol_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        one_q  <= 1'b0;
        viol_q <= 1'b0;
      end else begin
        if (init_i) one_q <= (limit_i == ONE_W);
        if (viol_set) viol_q <= 1'b1;
      end
    end
    assign one_o  = one_q;
    assign viol_o = viol_q;

    // R10
    viol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol_o |=> viol_o);

    // R9
    one_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_i && limit_i == ONE_W) |=> one_o);

    // R9
    one_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !init_i |=> $stable(one_o));
  end else begin : g_noflags
    assign one_o  = 1'b0;
    assign viol_o = 1'b0;
  end
endmodule

// File: rtl/tx_credit_monitor.sv
module tx_credit_monitor
  import tx_credit_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fc_init_i,
  input  logic [NPOOL*CNT_W-1:0] init_limit_i,
  input  logic                   consume_i,
  input  logic [1:0]             consume_class_i,
  input  logic [AMT_H_W-1:0]     consume_hdr_i,
  input  logic [CNT_W-1:0]       consume_data_i,
  input  logic                   return_i,
  input  logic [1:0]             return_class_i,
  input  logic [AMT_H_W-1:0]     return_hdr_i,
  input  logic [CNT_W-1:0]       return_data_i,
  output logic [STATUS_W-1:0]    cred_status_o,
  output logic                   np_hdr_one_o,
  output logic                   np_data_one_o,
  output logic                   np_hdr_viol_o,
  output logic                   np_data_viol_o
);
  localparam logic [NPOOL-1:0] NPH_MASK = NPOOL'(1) << NPH_IDX;
  localparam logic [NPOOL-1:0] NPD_MASK = NPOOL'(1) << NPD_IDX;

  logic [NPOOL*CNT_W-1:0] cons_amt, ret_amt;
  logic [NPOOL-1:0]       one_w, viol_w;

  tx_credit_decode u_decode (
    .consume_i       (consume_i),
    .consume_class_i (consume_class_i),
    .consume_hdr_i   (consume_hdr_i),
    .consume_data_i  (consume_data_i),
    .return_i        (return_i),
    .return_class_i  (return_class_i),
    .return_hdr_i    (return_hdr_i),
    .return_data_i   (return_data_i),
    .cons_amt_o      (cons_amt),
    .ret_amt_o       (ret_amt)
  );

  for (genvar p = 0; p < NPOOL; p++) begin : g_pool
    localparam int FW  = pool_fw(p);
    localparam int LSB = pool_lsb(p);
    tx_credit_pool #(
      .CW        (CNT_W),
      .FW        (FW),
      .HAS_FLAGS (p == NPH_IDX || p == NPD_IDX)
    ) u_pool (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .init_i  (fc_init_i),
      .limit_i (init_limit_i[p*CNT_W +: CNT_W]),
      .cons_i  (cons_amt[p*CNT_W +: CNT_W]),
      .ret_i   (ret_amt[p*CNT_W +: CNT_W]),
      .field_o (cred_status_o[LSB +: FW]),
      .one_o   (one_w[p]),
      .viol_o  (viol_w[p])
    );
  end

  // only the non-posted pools carry flags; others read 0
  assign np_hdr_one_o   = |(one_w & NPH_MASK);
  assign np_data_one_o  = |(one_w & NPD_MASK);
  assign np_hdr_viol_o  = |(viol_w & NPH_MASK);
  assign np_data_viol_o = |(viol_w & NPD_MASK);

  // R1
  rst_clear_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (cred_status_o == '0 && !np_hdr_viol_o && !np_data_viol_o));
endmodule

// File: tb/tx_credit_monitor_tb.sv
`timescale 1ns/1ps
module tx_credit_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fc_init = 1'b0;
  logic [95:0] init_limit = '0;
  logic        consume = 1'b0;
  logic [1:0]  consume_class = '0;
  logic [7:0]  consume_hdr = '0;
  logic [15:0] consume_data = '0;
  logic        ret = 1'b0;
  logic [1:0]  return_class = '0;
  logic [7:0]  return_hdr = '0;
  logic [15:0] return_data = '0;
  logic [35:0] status;
  logic        nph_one, npd_one, nph_viol, npd_viol;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int cnt [6];
  bit inf [6];
  bit one_m [2];
  bit viol_m [2];
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  tx_credit_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fc_init_i(fc_init), .init_limit_i(init_limit),
    .consume_i(consume), .consume_class_i(consume_class),
    .consume_hdr_i(consume_hdr), .consume_data_i(consume_data),
    .return_i(ret), .return_class_i(return_class),
    .return_hdr_i(return_hdr), .return_data_i(return_data),
    .cred_status_o(status), .np_hdr_one_o(nph_one), .np_data_one_o(npd_one),
    .np_hdr_viol_o(nph_viol), .np_data_viol_o(npd_viol)
  );

  function automatic int fw_of(int p);
    return ((p % 2) == 1 && p != 3) ? 12 : 3;
  endfunction

  function automatic logic [35:0] exp_status();
    logic [35:0] s = '0;
    int lsb = 0;
    for (int p = 0; p < 6; p++) begin
      int mx = (1 << fw_of(p)) - 1;
      int v = inf[p] ? mx : ((cnt[p] > mx) ? mx : cnt[p]);
      s |= 36'(v) << lsb;
      lsb += fw_of(p);
    end
    return s;
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, 64'(status), 64'(exp_status()));
    chk(req, 64'({nph_one, npd_one}), 64'({one_m[0], one_m[1]}));
    chk(req, 64'({nph_viol, npd_viol}), 64'({viol_m[0], viol_m[1]}));
  endtask

  task automatic model_reset();
    for (int p = 0; p < 6; p++) begin cnt[p] = 0; inf[p] = 1'b0; end
    for (int i = 0; i < 2; i++) begin one_m[i] = 1'b0; viol_m[i] = 1'b0; end
  endtask

  // one event cycle: drive at negedge, model, compare at next negedge
  task automatic step(bit do_init, logic [95:0] lim,
                      bit c_en, int c_cls, int c_h, int c_d,
                      bit r_en, int r_cls, int r_h, int r_d, string req);
    fc_init = do_init; init_limit = lim;
    consume = c_en; consume_class = 2'(c_cls);
    consume_hdr = 8'(c_h); consume_data = 16'(c_d);
    ret = r_en; return_class = 2'(r_cls);
    return_hdr = 8'(r_h); return_data = 16'(r_d);
    for (int p = 0; p < 6; p++) begin
      if (do_init) begin
        cnt[p] = int'(lim[p*16 +: 16]);
        inf[p] = (cnt[p] == 0);
        if (p == 2 || p == 3) one_m[p-2] = (cnt[p] == 1);
      end else if (!inf[p]) begin
        int a = cnt[p];
        int cs = (c_en && c_cls == p/2) ? ((p % 2) ? c_d : c_h) : 0;
        int rs = (r_en && r_cls == p/2) ? ((p % 2) ? r_d : r_h) : 0;
        a = a + rs;
        if (a > 65535) a = 65535;
        if (cs > a) begin
          a = 0;
          if (p == 2 || p == 3) viol_m[p-2] = 1'b1;
        end else a = a - cs;
        cnt[p] = a;
      end
    end
    @(negedge clk);
    fc_init = 1'b0; consume = 1'b0; ret = 1'b0;
    check_all(req);
  endtask

  function automatic logic [95:0] pack(int a, int b, int c, int d, int e, int f);
    return {16'(f), 16'(e), 16'(d), 16'(c), 16'(b), 16'(a)};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2 distinct limits per pool, slice checks
    step(1, pack(5, 1000, 6, 2, 3, 4000), 0,0,0,0, 0,0,0,0, "R3");
    chk("R2", 64'(status[2:0]), 5);
    chk("R2", 64'(status[14:3]), 1000);
    chk("R2", 64'(status[17:15]), 6);
    chk("R2", 64'(status[20:18]), 2);
    chk("R2", 64'(status[23:21]), 3);
    chk("R2", 64'(status[35:24]), 4000);

    // R4 saturation then countdown into range
    step(1, pack(9, 5000, 20, 8, 7, 4100), 0,0,0,0, 0,0,0,0, "R4");
    step(0, '0, 1, 0, 1, 904, 0,0,0,0, "R4");
    step(0, '0, 1, 0, 1, 1, 0,0,0,0, "R4");
    step(0, '0, 1, 2, 0, 4, 0,0,0,0, "R4");
    step(0, '0, 1, 2, 0, 1, 0,0,0,0, "R4");
    // R5 class code 3 touches nothing
    step(0, '0, 1, 3, 3, 3, 0,0,0,0, "R5");
    // R7 return first, then consume; floor at 0
    step(0, '0, 1, 1, 25, 5, 1, 1, 6, 1, "R7");
    // R6 count ceiling 65535
    step(1, pack(3, 65530, 3, 3, 3, 3), 0,0,0,0, 0,0,0,0, "R3");
    step(0, '0, 0,0,0,0, 1, 0, 0, 100, "R6");
    step(0, '0, 1, 0, 0, 65535, 0,0,0,0, "R6");
    // R3 init wins over same-cycle traffic
    step(1, pack(4, 4, 4, 4, 4, 4), 1, 1, 2, 2, 1, 0, 2, 2, "R3");
    // R8 unlimited pools
    step(1, pack(0, 0, 0, 0, 2, 0), 0,0,0,0, 0,0,0,0, "R8");
    step(0, '0, 1, 1, 200, 60000, 0,0,0,0, "R8");
    step(0, '0, 1, 0, 9, 9, 1, 0, 1, 1, "R8");
    // R9 single-credit flags set then cleared
    step(1, pack(3, 3, 1, 1, 3, 3), 0,0,0,0, 0,0,0,0, "R9");
    step(0, '0, 1, 1, 1, 0, 1, 2, 1, 1, "R9");
    step(1, pack(3, 3, 2, 1, 3, 3), 0,0,0,0, 0,0,0,0, "R9");
    // R10 violation sticky across reinit
    step(0, '0, 1, 1, 3, 0, 0,0,0,0, "R10");
    step(1, pack(3, 3, 5, 5, 3, 3), 0,0,0,0, 0,0,0,0, "R10");
    step(0, '0, 1, 1, 1, 6, 0,0,0,0, "R10");

    // pseudo-random sweep
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = rnd();
      if (i % 50 == 0) begin
        logic [95:0] lim;
        for (int p = 0; p < 6; p++) begin
          int v = (p % 2 && p != 3) ? int'(rnd() % 4200) : int'(rnd() % 12);
          if (rnd() % 7 == 0) v = 0;
          if (rnd() % 7 == 0) v = 1;
          lim[p*16 +: 16] = 16'(v);
        end
        step(1, lim, 0,0,0,0, 0,0,0,0, "R3");
      end else begin
        bit ce = r[0];
        bit re = r[1] & r[2];
        int cc = int'(rnd() % 4);
        int rc = int'(rnd() % 4);
        int ch = int'(rnd() % 4);
        int cd = int'(rnd() % 9) + ((rnd() % 5 == 0) ? int'(rnd() % 600) : 0);
        int rh = int'(rnd() % 3);
        int rd = int'(rnd() % 6);
        string tag = (ce && re) ? "R7" : (re ? "R6" : "R5");
        step(0, '0, ce, cc, ch, cd, re, rc, rh, rd, tag);
      end
    end

    // R1/R10 reset clears sticky flags
    step(1, pack(1, 1, 1, 1, 1, 1), 0,0,0,0, 0,0,0,0, "R9");
    step(0, '0, 1, 1, 4, 4, 0,0,0,0, "R10");
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R10");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule